// File: doc/BRIEF.md
# One-Hot Pointer FIFO with Health Alarms

This block is a small ring buffer whose write and read positions are held as one-hot shift registers, each rotating by one place per strobe. Both pointers run on one clock. A sync pulse puts them half a ring apart. Every cycle the block checks the pointers. A write pointer that has decayed to all zeros is reported, and it stays stuck until the next sync. The distance between the pointers is graded as two apart, one apart or colliding.

The block also takes two clock-lost flags from outside detectors. All conditions collect into a sticky alarm word, which software clears by writing ones. When an enabled fault is held in that word, a mute bit sets and the data output shows the midscale code 0x8000 in place of the stored word. A debug input can zero the write pointer, so the stuck-pointer path can be exercised.

Top module: `onehot_fifo_guard`

## Requirements
- R1: During reset and after it, all alarm bits are 0, every storage entry holds 0, the write pointer sits at position 0 and the read pointer sits at position RD_GAP (4).
- R2: A write strobe stores wr_data at the write position and then rotates that pointer one place. A read strobe rotates the read pointer one place. While unmuted, rd_data shows the entry at the read position.
- R3: A sync pulse reloads the write pointer to position 0 and the read pointer to position 4. Any write or read strobe in the same cycle is ignored.
- R4: The debug input zeroes the write pointer, and the write in that same cycle is dropped. A zero write pointer ignores write strobes until a sync. Alarm bit 0 sets in the cycle after the pointer is seen at zero.
- R5: The distance code is held in alarm bits [3:1] and graded by priority. Bit 3 sets when the pointers are equal. Otherwise bit 2 sets when they are one place apart in either direction. Otherwise bit 1 sets when they are two places apart. Each bit appears one cycle after the condition is seen.
- R6: Alarm bits are sticky. Writing clr_we=1 clears every bit where clr_mask is 1. An event in the same cycle as a clear keeps that bit set.
- R7: dst_clk_lost sets alarm bit 4 and src_clk_lost sets alarm bit 5, whatever the enable inputs are.
- R8: Alarm bit 6 (mute) sets when an enabled cause bit is held: bit 3 with collide_ena, bit 4 with dst_lost_ena, or bit 5 with src_lost_ena. While bit 6 is set, rd_data is 0x8000.
- R9: The mute bit clears only through a write-to-clear, and only if its enabled cause bits are cleared in the same cycle or are already clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both pointers and all state |
| rst_n | input | 1 | Synchronous active-low reset |
| sync | input | 1 | Pointer resynchronisation pulse |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 16 | Word to store |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 16 | Word at read position, or 0x8000 when muted |
| dbg_wptr_clear | input | 1 | Debug: force the write pointer to zero |
| collide_ena | input | 1 | Collision contributes to mute |
| dst_lost_ena | input | 1 | Lost destination clock contributes to mute |
| src_lost_ena | input | 1 | Lost source clock contributes to mute |
| dst_clk_lost | input | 1 | Destination clock-lost flag |
| src_clk_lost | input | 1 | Source clock-lost flag |
| clr_we | input | 1 | Write-to-clear strobe |
| clr_mask | input | 7 | Alarm bits to clear |
| alarms | output | 7 | Sticky alarm word |

## Verification
The stuck write pointer is the hardest state to reach. With a correct pointer it can only arise from corruption, which no port sequence can produce. The bench therefore drives the debug input, sends write strobes at the dead pointer, and checks that storage and rd_data are unchanged until a sync revives it. The other hard case is a clear that coincides with a new event or with a still-enabled cause. The stimulus times clear strobes against collisions and held clock-lost flags on the exact cycle.

// File: rtl/onehot_fifo_pkg.sv
// Package: shared alarm bit positions and widths for the one-hot FIFO.
// Assumes the alarm word layout below is the only one software sees.
package onehot_fifo_pkg;
    localparam int ALARM_W   = 7;
    localparam int CAUSE_W   = 6;
    localparam int A_ZERO    = 0;
    localparam int A_TWO     = 1;
    localparam int A_ONE     = 2;
    localparam int A_COLL    = 3;
    localparam int A_DST     = 4;
    localparam int A_SRC     = 5;
    localparam int A_MUTE    = 6;
    typedef logic [ALARM_W-1:0] alarm_t;
endpackage

// File: rtl/onehot_ring_ptr.sv
// Module: one-hot ring pointer. Rotates one place on step, reloads to
// INIT_POS on load, drops to all zeros on kill. An all-zeros value
// rotates to itself, so it stays stuck until load.
// Assumes load has priority over kill, and kill over step.
module onehot_ring_ptr #(
    parameter int N        = 8,
    parameter int INIT_POS = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         kill,
    input  logic         step,
    output logic [N-1:0] ptr
);
    localparam logic [N-1:0] INIT_VAL = N'(1) << INIT_POS;

    // Pointer register: reset, reload, corrupt or rotate.
    always_ff @(posedge clk) begin
        if (!rst_n || load)
            ptr <= INIT_VAL;
        else if (kill)
            ptr <= '0;
        else if (step)
            ptr <= {ptr[N-2:0], ptr[N-1]};
    end

    // R1: pointer never holds more than one set bit
    a_r1_ptr_onehot0: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ptr));
    // R3: a load puts the pointer at its home position
    a_r3_load_home: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> ptr == INIT_VAL);
    // R4: a zero pointer stays zero without a load
    a_r4_zero_stuck: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr == '0 && !load) |=> ptr == '0);
endmodule

// File: rtl/ptr_gap_grade.sv
// Module: grades the distance between two one-hot pointers into
// collision, one apart and two apart, with collision first.
// Assumes N >= 5 so the rotations used are all distinct.
module ptr_gap_grade #(
    parameter int N = 8
) (
    input  logic [N-1:0] wptr,
    input  logic [N-1:0] rptr,
    output logic         coll,
    output logic         near1,
    output logic         near2
);
    logic [N-1:0] r_up1, r_dn1, r_up2, r_dn2;

    // Rotated copies of the read pointer, both directions.
    always_comb begin
        r_up1 = {rptr[N-2:0], rptr[N-1]};
        r_dn1 = {rptr[0], rptr[N-1:1]};
        r_up2 = {rptr[N-3:0], rptr[N-1:N-2]};
        r_dn2 = {rptr[1:0], rptr[N-1:2]};
    end

    // Priority grading of the match results.
    always_comb begin
        coll  = (|wptr) && (wptr == rptr);
        near1 = !coll && (|wptr) && (wptr == r_up1 || wptr == r_dn1);
        near2 = !coll && !near1 && (|wptr) && (wptr == r_up2 || wptr == r_dn2);
    end
endmodule

// File: rtl/sticky_w2c.sv
// Module: row of sticky bits with write-to-clear. A set event in the
// same cycle as a clear wins. nxt exposes the next value.
// Assumes clr is already gated by the software write strobe.
module sticky_w2c #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_evt,
    input  logic [W-1:0] clr,
    output logic [W-1:0] nxt,
    output logic [W-1:0] q
);
    // Next value: held bits minus cleared ones, plus new events.
    always_comb nxt = (q & ~clr) | set_evt;

    // Storage of the sticky bits.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else
            q <= nxt;
    end

    // R6: a set bit that is not cleared stays set
    a_r6_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(q) & ~$past(clr)) & ~q) == '0);
    // R6: a bit with an event in the previous cycle is set
    a_r6_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($past(set_evt) & ~q) == '0);
endmodule

// File: rtl/onehot_fifo_guard.sv
// Module: top of the one-hot pointer FIFO with health alarms. Holds
// DEPTH words addressed by one-hot pointers, grades pointer distance,
// keeps a sticky alarm word and mutes the output to MIDSCALE while an
// enabled fault is held. Assumes one clock for writer and reader.
module onehot_fifo_guard
    import onehot_fifo_pkg::*;
#(
    parameter int          DATA_W   = 16,
    parameter int          DEPTH    = 8,
    parameter int          RD_GAP   = DEPTH / 2,
    parameter logic [15:0] MIDSCALE = 16'h8000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    input  logic              dbg_wptr_clear,
    input  logic              collide_ena,
    input  logic              dst_lost_ena,
    input  logic              src_lost_ena,
    input  logic              dst_clk_lost,
    input  logic              src_clk_lost,
    input  logic              clr_we,
    input  logic [ALARM_W-1:0] clr_mask,
    output logic [ALARM_W-1:0] alarms
);
    localparam logic [DATA_W-1:0] MUTE_WORD = DATA_W'(MIDSCALE);

    logic [DEPTH-1:0]  wptr, rptr;
    logic              wr_ok;
    logic              g_coll, g_near1, g_near2;
    logic [ALARM_W-1:0] clr_eff;
    logic [CAUSE_W-1:0] cause_evt, cause_nxt, cause_q;
    logic [0:0]         mute_evt, mute_nxt, mute_q;
    logic [DATA_W-1:0]  mem [DEPTH];
    logic [DATA_W-1:0]  sel_word;

    // A write lands only outside sync and corruption cycles.
    always_comb wr_ok = wr_en && !sync && !dbg_wptr_clear;

    onehot_ring_ptr #(.N(DEPTH), .INIT_POS(0)) u_wptr (
        .clk(clk), .rst_n(rst_n), .load(sync), .kill(dbg_wptr_clear),
        .step(wr_en), .ptr(wptr));

    onehot_ring_ptr #(.N(DEPTH), .INIT_POS(RD_GAP)) u_rptr (
        .clk(clk), .rst_n(rst_n), .load(sync), .kill(1'b0),
        .step(rd_en), .ptr(rptr));

    ptr_gap_grade #(.N(DEPTH)) u_gap (
        .wptr(wptr), .rptr(rptr), .coll(g_coll), .near1(g_near1), .near2(g_near2));

    // Storage: one register per entry, written when its pointer bit is hot.
    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n)
                mem[i] <= '0;
            else if (wr_ok && wptr[i])
                mem[i] <= wr_data;
        end
    end

    // One-hot read mux: OR of the entry selected by the read pointer.
    always_comb begin
        sel_word = '0;
        for (int i = 0; i < DEPTH; i++)
            if (rptr[i]) sel_word = sel_word | mem[i];
    end

    // Gated clear mask and raw cause events.
    always_comb begin
        clr_eff           = clr_we ? clr_mask : '0;
        cause_evt         = '0;
        cause_evt[A_ZERO] = (wptr == '0);
        cause_evt[A_TWO]  = g_near2;
        cause_evt[A_ONE]  = g_near1;
        cause_evt[A_COLL] = g_coll;
        cause_evt[A_DST]  = dst_clk_lost;
        cause_evt[A_SRC]  = src_clk_lost;
    end

    sticky_w2c #(.W(CAUSE_W)) u_cause (
        .clk(clk), .rst_n(rst_n), .set_evt(cause_evt), .clr(clr_eff[CAUSE_W-1:0]),
        .nxt(cause_nxt), .q(cause_q));

    // Mute event from enabled cause bits as they will stand next cycle.
    always_comb mute_evt[0] = (collide_ena  && cause_nxt[A_COLL])
                            || (dst_lost_ena && cause_nxt[A_DST])
                            || (src_lost_ena && cause_nxt[A_SRC]);

    sticky_w2c #(.W(1)) u_mute (
        .clk(clk), .rst_n(rst_n), .set_evt(mute_evt), .clr(clr_eff[A_MUTE:A_MUTE]),
        .nxt(mute_nxt), .q(mute_q));

    // Output word and alarm word.
    always_comb begin
        alarms  = {mute_q, cause_q};
        rd_data = mute_q[0] ? MUTE_WORD : sel_word;
    end

    // R8: an enabled collision seen now mutes the next cycle
    a_r8_coll_mutes: assert property (@(posedge clk) disable iff (!rst_n)
        (collide_ena && g_coll) |=> alarms[A_MUTE]);
    // R8: while muted the output carries the midscale word
    a_r8_mute_word: assert property (@(posedge clk) disable iff (!rst_n)
        alarms[A_MUTE] |-> rd_data == MUTE_WORD);
    // R4: a zero write pointer raises the zero alarm next cycle
    a_r4_zero_alarm: assert property (@(posedge clk) disable iff (!rst_n)
        (wptr == '0) |=> alarms[A_ZERO]);
    // R5: at most one distance grade fires per cycle
    a_r5_one_grade: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({g_coll, g_near1, g_near2}));
endmodule

// File: tb/onehot_fifo_guard_test.sv
`timescale 1ns/1ps
module onehot_fifo_guard_test;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        sync = 0, wr_en = 0, rd_en = 0, dbg_wptr_clear = 0;
    logic [15:0] wr_data = 0;
    logic [15:0] rd_data;
    logic        collide_ena = 0, dst_lost_ena = 0, src_lost_ena = 0;
    logic        dst_clk_lost = 0, src_clk_lost = 0, clr_we = 0;
    logic [6:0]  clr_mask = 0;
    logic [6:0]  alarms;

    int checks = 0, errors = 0;
    bit done = 0;

    // reference model state
    int          mw, mr;
    logic [15:0] mm [8];
    logic [6:0]  ma;

    always #5 clk = ~clk;

    onehot_fifo_guard uut (
        .clk(clk), .rst_n(rst_n), .sync(sync), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .dbg_wptr_clear(dbg_wptr_clear),
        .collide_ena(collide_ena), .dst_lost_ena(dst_lost_ena),
        .src_lost_ena(src_lost_ena), .dst_clk_lost(dst_clk_lost),
        .src_clk_lost(src_clk_lost), .clr_we(clr_we), .clr_mask(clr_mask),
        .alarms(alarms));

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        mw = 0; mr = 4; ma = '0;
        for (int i = 0; i < 8; i++) mm[i] = '0;
    endtask

    task automatic model_edge();
        logic [6:0] ev, clr, nx;
        int d;
        ev = '0;
        clr = clr_we ? clr_mask : '0;
        if (mw < 0) ev[0] = 1;
        else begin
            d = (mw - mr + 8) % 8;
            if (d == 0) ev[3] = 1;
            else if (d == 1 || d == 7) ev[2] = 1;
            else if (d == 2 || d == 6) ev[1] = 1;
        end
        ev[4] = dst_clk_lost;
        ev[5] = src_clk_lost;
        nx[5:0] = (ma[5:0] & ~clr[5:0]) | ev[5:0];
        nx[6] = (ma[6] & ~clr[6]) | (collide_ena & nx[3]) | (dst_lost_ena & nx[4])
                | (src_lost_ena & nx[5]);
        ma = nx;
        if (sync) begin
            mw = 0; mr = 4;
        end else begin
            if (dbg_wptr_clear) mw = -1;
            else if (wr_en && mw >= 0) begin
                mm[mw] = wr_data;
                mw = (mw + 1) % 8;
            end
            if (rd_en) mr = (mr + 1) % 8;
        end
    endtask

    task automatic compare();
        chk("R2/R8 rd_data", rd_data, ma[6] ? 16'h8000 : mm[mr]);
        chk("R5 distance bits", {13'd0, alarms[3:1]}, {13'd0, ma[3:1]});
        chk("R4 zero alarm", {15'd0, alarms[0]}, {15'd0, ma[0]});
        chk("R7 clock-lost bits", {14'd0, alarms[5:4]}, {14'd0, ma[5:4]});
        chk("R8/R9 mute bit", {15'd0, alarms[6]}, {15'd0, ma[6]});
    endtask

    task automatic cyc();
        @(posedge clk);
        if (!rst_n) model_reset(); else model_edge();
        @(negedge clk);
        compare();
    endtask

    task automatic idle();
        sync = 0; wr_en = 0; rd_en = 0; dbg_wptr_clear = 0;
        clr_we = 0; clr_mask = 0; dst_clk_lost = 0; src_clk_lost = 0;
    endtask

    task automatic clear_all();
        clr_we = 1; clr_mask = 7'h7f; cyc(); clr_we = 0; clr_mask = 0;
    endtask

    initial begin
        model_reset();
        repeat (3) cyc();
        // R1: reset state
        chk("R1 alarms after reset", {9'd0, alarms}, 16'd0);
        chk("R1 rd_data after reset", rd_data, 16'd0);
        rst_n = 1;
        cyc();
        chk("R1 alarms idle", {9'd0, alarms}, 16'd0);

        // R2/R5: four writes walk the write pointer onto the reader
        for (int i = 0; i < 4; i++) begin
            wr_en = 1; wr_data = 16'h1100 + 16'(i); cyc();
        end
        idle(); cyc();
        chk("R5 collision graded", {13'd0, alarms[3:1]}, 16'h0007);
        clear_all();
        // R2: read round to written words
        for (int i = 0; i < 6; i++) begin rd_en = 1; cyc(); end
        idle(); cyc();
        chk("R2 read word", rd_data, 16'h1102);

        // R3: sync with a write strobe; strobe ignored
        sync = 1; wr_en = 1; wr_data = 16'hdead; cyc();
        idle(); cyc(); clear_all(); cyc();
        chk("R3 sync clean", {9'd0, alarms}, 16'd0);
        chk("R3 read pos 4", rd_data, mm[4]);

        // R8: enabled collision mutes
        collide_ena = 1;
        for (int i = 0; i < 4; i++) begin wr_en = 1; wr_data = 16'h2200 + 16'(i); cyc(); end
        idle(); cyc();
        chk("R8 muted word", rd_data, 16'h8000);
        // R9: clear mute alone while collision held -> stays muted
        clr_we = 1; clr_mask = 7'h40; cyc(); idle(); cyc();
        chk("R9 mute kept", {15'd0, alarms[6]}, 16'd1);
        // R9: sync then clear all -> unmuted
        sync = 1; cyc(); idle(); clear_all(); cyc();
        chk("R9 mute released", {15'd0, alarms[6]}, 16'd0);
        collide_ena = 0;

        // R7: clock-lost flags latch with enables off, no mute
        src_clk_lost = 1; dst_clk_lost = 1; cyc(); idle(); cyc();
        chk("R7 both lost latched", {14'd0, alarms[5:4]}, 16'd3);
        chk("R7 no mute", {15'd0, alarms[6]}, 16'd0);
        // R8: enabling with bit held mutes
        dst_lost_ena = 1; cyc(); cyc();
        chk("R8 dst lost mutes", {15'd0, alarms[6]}, 16'd1);
        clear_all(); cyc();
        chk("R9 cleared together", {9'd0, alarms}, 16'd0);
        // R6: clear coincident with event keeps bit
        src_clk_lost = 1; clr_we = 1; clr_mask = 7'h20; cyc(); idle(); cyc();
        chk("R6 event beats clear", {15'd0, alarms[5]}, 16'd1);
        clear_all(); dst_lost_ena = 0;

        // R4: stuck write pointer
        dbg_wptr_clear = 1; wr_en = 1; wr_data = 16'hbad0; cyc(); idle();
        for (int i = 0; i < 5; i++) begin wr_en = 1; wr_data = 16'hbad1; cyc(); end
        idle(); cyc();
        chk("R4 zero alarm set", {15'd0, alarms[0]}, 16'd1);
        for (int i = 0; i < 8; i++) begin
            chk("R4 storage untouched", rd_data, mm[mr]);
            chk("R4 no stuck write", (rd_data == 16'hbad1 || rd_data == 16'hbad0) ? 16'd1 : 16'd0, 16'd0);
            rd_en = 1; cyc(); rd_en = 0;
        end
        sync = 1; cyc(); idle(); clear_all(); cyc();
        chk("R4 recovered", {15'd0, alarms[0]}, 16'd0);

        // mixed random traffic
        for (int i = 0; i < 600; i++) begin
            wr_en = $urandom_range(0, 1) == 1;
            rd_en = $urandom_range(0, 1) == 1;
            wr_data = 16'($urandom);
            sync = $urandom_range(0, 40) == 0;
            dbg_wptr_clear = $urandom_range(0, 60) == 0;
            dst_clk_lost = $urandom_range(0, 50) == 0;
            src_clk_lost = $urandom_range(0, 50) == 0;
            collide_ena = $urandom_range(0, 3) == 0;
            dst_lost_ena = $urandom_range(0, 3) == 0;
            src_lost_ena = $urandom_range(0, 3) == 0;
            clr_we = $urandom_range(0, 4) == 0;
            clr_mask = 7'($urandom);
            cyc();
        end
        idle(); cyc();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        done = 1;
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule